// File: doc/BRIEF.md
# Hash Message Byte-Length Tracker

This block keeps the number of message bytes still owed to a hash core. Software loads a 64-bit byte count through two 32-bit register halves. Each 32-bit data word then accepted from either the bus write port or the FIFO port takes four bytes off the count. When the word being accepted is the final one of the message, the block raises a last-word flag toward the hash core. In the same cycle it gives a two-bit code that says how many byte lanes of that word carry message data.

In a multi-part hash, software can load a large placeholder count for the parts that are not final, for example with only bit 63 set. The last-word flag then never fires during those parts. For the final part it loads the true remaining size. Once the count reaches zero, the block raises a done flag and ignores further words until the count is loaded again.

Top module: `msg_len_tracker`

## Requirements
- R1: After reset the count is zero, `done_o` is 1 and `last_word_o` is 0.
- R2: A register write with `reg_hi_sel_i` = 0 loads count bits 31:0 from `reg_wdata_i` on the next clock edge and leaves bits 63:32 unchanged.
- R3: A register write with `reg_hi_sel_i` = 1 loads count bits 63:32 from `reg_wdata_i` on the next clock edge and leaves bits 31:0 unchanged.
- R4: A word accepted from either port while the count is at least 4 reduces the count by exactly 4 on the next edge.
- R5: The subtraction takes a borrow from the low half into the high half. For example, a count of 0x1_00000002 becomes 0x0_FFFFFFFE after one word.
- R6: A word accepted while the count is 1, 2 or 3 sets the count to zero.
- R7: `last_word_o` is 1 in the cycle a word is presented if and only if the count before that word is between 1 and 4 inclusive. A count of 2^63 never produces it.
- R8: While `last_word_o` is 1, `last_byte_sel_o` equals (count − 1) mod 4. The value 0 means 1 valid byte and the value 3 means 4 valid bytes. While `last_word_o` is 0, `last_byte_sel_o` is 0.
- R9: `done_o` is 1 exactly when the count is zero. Words presented at zero leave the count at zero and do not raise `last_word_o`.
- R10: When a register write and a word arrive in the same cycle, the write takes effect and the word causes no decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_hi_sel_i | input | 1 | Selects the half to write: 0 = bits 31:0, 1 = bits 63:32 |
| reg_wdata_i | input | 32 | Register write data |
| bus_word_vld_i | input | 1 | Data word accepted on the bus port |
| fifo_word_vld_i | input | 1 | Data word accepted on the FIFO port |
| last_word_o | output | 1 | The word presented this cycle is the final word of the message |
| last_byte_sel_o | output | 2 | Valid bytes in the final word, minus one |
| done_o | output | 1 | Count is zero |
| count_o | output | 64 | Remaining byte count |

## Verification
The assertions assume that the bus and FIFO ports never both present a word in the same cycle, because the block accepts at most one word per clock. One assertion checks this assumption. The bench drives the two valid inputs only from separate tasks, so at most one of them is high in any cycle. A register write may coincide with a word, and the bench drives that case on purpose.

// File: rtl/msg_len_pkg.sv
package msg_len_pkg;
  typedef enum logic [0:0] {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/msg_len_next.sv
// Next-count arithmetic: saturating subtract of one word, with borrow between the halves.
module msg_len_next #(
  parameter int HALF_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [HALF_W-1:0] cnt_lo_i,
  input  logic [HALF_W-1:0] cnt_hi_i,
  output logic [HALF_W-1:0] nxt_lo_o,
  output logic [HALF_W-1:0] nxt_hi_o,
  output logic              below_o
);
  localparam logic [HALF_W:0]   WB_EXT = (HALF_W+1)'(WORD_BYTES);
  localparam logic [HALF_W-1:0] WB     = HALF_W'(WORD_BYTES);

  logic [HALF_W:0] lo_diff;
  logic            borrow;

  always_comb begin
    lo_diff = {1'b0, cnt_lo_i} - WB_EXT;
    borrow  = lo_diff[HALF_W];
    below_o = (cnt_hi_i == '0) && (cnt_lo_i < WB);
    if (below_o) begin
      nxt_lo_o = '0;
      nxt_hi_o = '0;
    end else begin
      nxt_lo_o = lo_diff[HALF_W-1:0];
      nxt_hi_o = cnt_hi_i - HALF_W'(borrow);
    end
  end
endmodule

// File: rtl/msg_len_lastdet.sv
// Decides whether this word is the last one, and how many of its byte lanes are valid.
module msg_len_lastdet #(
  parameter int HALF_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int SEL_W     = $clog2(WORD_BYTES)
) (
  input  logic [HALF_W-1:0] cnt_lo_i,
  input  logic [HALF_W-1:0] cnt_hi_i,
  input  logic              word_i,
  output logic              last_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              zero_o
);
  localparam logic [HALF_W-1:0] WB = HALF_W'(WORD_BYTES);

  logic near_end;

  always_comb begin
    zero_o   = (cnt_hi_i == '0) && (cnt_lo_i == '0);
    near_end = (cnt_hi_i == '0) && !zero_o && (cnt_lo_i <= WB);
    last_o   = word_i && near_end;
    sel_o    = last_o ? SEL_W'(cnt_lo_i[SEL_W-1:0] - 1'b1) : '0;
  end
endmodule

// File: rtl/msg_len_half.sv
// One 32-bit half of the count register.
module msg_len_half #(
  parameter int HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] load_val_i,
  input  logic              dec_i,
  input  logic [HALF_W-1:0] dec_val_i,
  output logic [HALF_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (dec_i)  q_o <= dec_val_i;
  end
endmodule

// File: rtl/msg_len_tracker.sv
module msg_len_tracker #(
  parameter int HALF_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = 2 * HALF_W,
  localparam int SEL_W     = $clog2(WORD_BYTES),
  localparam int N_HALVES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_hi_sel_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  input  logic              bus_word_vld_i,
  input  logic              fifo_word_vld_i,
  output logic              last_word_o,
  output logic [SEL_W-1:0]  last_byte_sel_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);
  import msg_len_pkg::*;

  localparam logic [HALF_W-1:0] WB = HALF_W'(WORD_BYTES);

  logic [HALF_W-1:0] q    [N_HALVES];
  logic [HALF_W-1:0] nxt  [N_HALVES];
  logic              word;
  logic              dec;
  logic              zero;
  logic              below;
  half_e             wsel;

  assign wsel = half_e'(reg_hi_sel_i);
  assign word = bus_word_vld_i | fifo_word_vld_i;

  msg_len_lastdet #(.HALF_W(HALF_W), .WORD_BYTES(WORD_BYTES)) u_lastdet (
    .cnt_lo_i (q[HALF_LO]),
    .cnt_hi_i (q[HALF_HI]),
    .word_i   (word),
    .last_o   (last_word_o),
    .sel_o    (last_byte_sel_o),
    .zero_o   (zero)
  );

  msg_len_next #(.HALF_W(HALF_W), .WORD_BYTES(WORD_BYTES)) u_next (
    .cnt_lo_i (q[HALF_LO]),
    .cnt_hi_i (q[HALF_HI]),
    .nxt_lo_o (nxt[HALF_LO]),
    .nxt_hi_o (nxt[HALF_HI]),
    .below_o  (below)
  );

  // A register write has priority over a word in the same cycle; words at zero are dropped.
  assign dec = word && !reg_we_i && !zero;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    msg_len_half #(.HALF_W(HALF_W)) u_half (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (reg_we_i && (int'(wsel) == h)),
      .load_val_i (reg_wdata_i),
      .dec_i      (dec),
      .dec_val_i  (nxt[h]),
      .q_o        (q[h])
    );
  end

  assign done_o  = zero;
  assign count_o = {q[HALF_HI], q[HALF_LO]};

  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_word_vld_i && fifo_word_vld_i)); // R4
  AST_LOAD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_hi_sel_i) |=> (count_o[HALF_W-1:0] == $past(reg_wdata_i))
      && (count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]))); // R2
  AST_LOAD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_hi_sel_i) |=> (count_o[CNT_W-1:HALF_W] == $past(reg_wdata_i))
      && (count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0]))); // R3
  AST_WORD_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word && !reg_we_i && (count_o >= CNT_W'(WORD_BYTES)))
      |=> count_o == $past(count_o) - CNT_W'(WORD_BYTES)); // R4
  AST_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word && !reg_we_i && (q[HALF_HI] != '0) && (q[HALF_LO] < WB))
      |=> count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]) - 1'b1); // R5
  AST_SAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word && !reg_we_i && below) |=> done_o); // R6
  AST_LAST_NEAR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_word_o |-> (count_o != '0) && (count_o <= CNT_W'(WORD_BYTES))); // R7
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_word_o |-> last_byte_sel_o == '0); // R8
  AST_DONE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !last_word_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && (!word || done_o)) |=> $stable(count_o)); // R9
endmodule

// File: tb/msg_len_tracker_tb_top.sv
module msg_len_tracker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_hi_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        bus_word_vld_i = 1'b0;
  logic        fifo_word_vld_i = 1'b0;
  logic        last_word_o;
  logic [1:0]  last_byte_sel_o;
  logic        done_o;
  logic [63:0] count_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  msg_len_tracker dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_hi_sel_i, .reg_wdata_i,
    .bus_word_vld_i, .fifo_word_vld_i,
    .last_word_o, .last_byte_sel_o, .done_o, .count_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_hi_sel_i = hi; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    wr(1'b1, v[63:32]);
    wr(1'b0, v[31:0]);
  endtask

  // Presents one word; samples the flags before the edge.
  task automatic push(input logic fifo, output logic lw, output logic [1:0] sel);
    @(negedge clk_i);
    if (fifo) fifo_word_vld_i = 1'b1; else bus_word_vld_i = 1'b1;
    #1; lw = last_word_o; sel = last_byte_sel_o;
    @(posedge clk_i); #1;
    bus_word_vld_i = 1'b0; fifo_word_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 count", count_o, 64'd0);
    chk("R1 done", 64'(done_o), 64'd1);
    chk("R1 last", 64'(last_word_o), 64'd0);
  endtask

  task automatic t_load();
    wr(1'b0, 32'h1234_5678);
    @(negedge clk_i); chk("R2 low load", count_o, 64'h0000_0000_1234_5678);
    chk("R9 done clear", 64'(done_o), 64'd0);
    wr(1'b1, 32'h0000_000A);
    @(negedge clk_i); chk("R3 high load", count_o, 64'h0000_000A_1234_5678);
    wr(1'b0, 32'hCAFE_0001);
    @(negedge clk_i); chk("R2 high kept", count_o, 64'h0000_000A_CAFE_0001);
  endtask

  task automatic t_dec();
    logic lw; logic [1:0] sel;
    load(64'd10);
    push(1'b0, lw, sel);
    chk("R7 no last at 10", 64'(lw), 64'd0);
    @(negedge clk_i); chk("R4 bus dec", count_o, 64'd6);
    push(1'b1, lw, sel);
    @(negedge clk_i); chk("R4 fifo dec", count_o, 64'd2);
    push(1'b0, lw, sel);
    chk("R7 last at 2", 64'(lw), 64'd1);
    chk("R8 sel at 2", 64'(sel), 64'd1);
    @(negedge clk_i); chk("R6 to zero", count_o, 64'd0);
    chk("R9 done", 64'(done_o), 64'd1);
    push(1'b1, lw, sel);
    chk("R9 no last at zero", 64'(lw), 64'd0);
    @(negedge clk_i); chk("R9 stays zero", count_o, 64'd0);
  endtask

  task automatic t_sel();
    logic lw; logic [1:0] sel;
    for (int n = 1; n <= 5; n++) begin
      load(64'(n));
      push(1'b0, lw, sel);
      chk($sformatf("R7 last n=%0d", n), 64'(lw), (n <= 4) ? 64'd1 : 64'd0);
      chk($sformatf("R8 sel n=%0d", n), 64'(sel), (n <= 4) ? 64'(n - 1) : 64'd0);
      @(negedge clk_i);
      chk($sformatf("R6 count n=%0d", n), count_o, (n <= 4) ? 64'd0 : 64'd1);
    end
  endtask

  task automatic t_borrow();
    logic lw; logic [1:0] sel;
    load(64'h0000_0001_0000_0002);
    push(1'b0, lw, sel);
    @(negedge clk_i); chk("R5 borrow lo<4", count_o, 64'h0000_0000_FFFF_FFFE);
    load(64'h0000_0001_0000_0004);
    push(1'b1, lw, sel);
    @(negedge clk_i); chk("R5 no borrow", count_o, 64'h0000_0001_0000_0000);
    load(64'h0000_0002_0000_0000);
    push(1'b0, lw, sel);
    @(negedge clk_i); chk("R5 borrow lo=0", count_o, 64'h0000_0001_FFFF_FFFC);
  endtask

  task automatic t_write_wins();
    load(64'd100);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_hi_sel_i = 1'b0; reg_wdata_i = 32'd50; bus_word_vld_i = 1'b1;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; bus_word_vld_i = 1'b0;
    @(negedge clk_i); chk("R10 write wins", count_o, 64'd50);
  endtask

  task automatic t_placeholder();
    logic lw; logic [1:0] sel;
    int seen = 0;
    load(64'h8000_0000_0000_0000);
    for (int i = 0; i < 20; i++) begin
      push(i[0], lw, sel);
      if (lw) seen++;
    end
    chk("R7 placeholder no last", 64'(seen), 64'd0);
    @(negedge clk_i); chk("R4 placeholder count", count_o, 64'h7FFF_FFFF_FFFF_FFB0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load();
    t_dec();
    t_sel();
    t_borrow();
    t_write_wins();
    t_placeholder();
    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule